// File: doc/BRIEF.md
# Per-Channel Block Sum Decimator

This block sits in front of long-window moving sums that would otherwise need a very deep sample history. Samples arrive time-multiplexed over several channels, one sample per channel in each sample period, each tagged with its channel index. For every channel the block keeps a private count of accepted samples and a running partial sum. When a channel's eighth sample arrives, the block releases one block value for that channel and starts a fresh group. A downstream long-window sum then steps once per block, so it needs one eighth of the storage.

The block value is either the full sum of the eight samples or their truncated average, the sum shifted right by three. A static mode input selects between the two. With the nominal 40 microsecond sample period, each channel yields one block value every 320 microseconds. Short windows of up to a few hundred samples are expected to use the raw stream directly and do not pass through this block.

Top module: `blksum_decim`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0. A synchronous reset clears every channel's count and partial sum, so a group that was cut short by reset is never emitted, and the first block after reset holds only samples accepted after reset.
- R2: `out_valid` is 1 for exactly one cycle on every eighth accepted sample of a channel. It rises in the same cycle that this eighth sample is presented with `in_valid` = 1, and it is 0 on every other cycle.
- R3: With `avg_mode` = 0, `out_value` equals the exact 11-bit sum of the eight samples in the group. Eight samples of 255 give 2040.
- R4: With `avg_mode` = 1, `out_value[7:0]` equals the group sum shifted right by 3, truncated, and `out_value[10:8]` is 0.
- R5: Channels are independent. Samples of other channels that are interleaved in any order leave a channel's count and sum unchanged.
- R6: When `out_valid` = 1, `out_chan` equals the `in_chan` of the eighth sample.
- R7: A cycle with `in_valid` = 0 advances no count and changes no sum, whatever `in_data` and `in_chan` hold, and `out_valid` is 0 in that cycle.
- R8: After a block is emitted, that channel's next block is built only from the following eight samples.
- R9: `avg_mode` is used only in the cycle the block is emitted. A change of `avg_mode` partway through a group does not alter the sum being built.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_chan | input | 4 | Channel index of the sample |
| in_data | input | 8 | Unsigned sample value |
| avg_mode | input | 1 | 1 = emit the average, 0 = emit the full sum |
| out_valid | output | 1 | Block value strobe |
| out_chan | output | 4 | Channel index of the emitted block |
| out_value | output | 11 | Block sum, or the average in the low 8 bits |

## Verification
The bench builds the block with its default parameters: 16 channels, 8-bit samples and groups of 8. At this size a round-robin sweep visits every channel at every count position, in both output modes. Blocks of all-255 and all-zero samples reach both ends of the 11-bit sum. Idle cycles carrying garbage data, a mode change partway through a group, and a reset in the middle of a group each show whether stray state leaks into later block values.

// File: rtl/blksum_pkg.sv
`timescale 1ns/1ps
// Shared types for the block-sum decimator.
package blksum_pkg;
    // Output mode selector: full sum or truncated average.
    typedef enum logic {
        MODE_SUM = 1'b0,
        MODE_AVG = 1'b1
    } blk_mode_e;
endpackage

// File: rtl/blksum_lane.sv
`timescale 1ns/1ps
// One channel's group counter and partial sum.
// Assumes the group size is 2**GROUP_LOG2, so the counter wraps naturally.
// The partial sum clears on the cycle the last sample of a group is taken.
module blksum_lane #(
    parameter int SAMPLE_W   = 8,
    parameter int GROUP_LOG2 = 3,
    localparam int SUM_W     = SAMPLE_W + GROUP_LOG2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic [SAMPLE_W-1:0]   sample,
    output logic [SUM_W-1:0]      part,
    output logic                  last
);
    logic [GROUP_LOG2-1:0] cnt;

    assign last = (cnt == {GROUP_LOG2{1'b1}});

    // Advance the count and accumulate, clearing both at group end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            part <= '0;
        end else if (take) begin
            cnt <= cnt + 1'b1;
            if (last)
                part <= '0;
            else
                part <= part + SUM_W'(sample);
        end
    end
endmodule

// File: rtl/blksum_shape.sv
`timescale 1ns/1ps
// Forms the emitted value from the completed group sum.
// Assumes the sum is unsigned and the average is a truncating shift.
module blksum_shape #(
    parameter int SAMPLE_W   = 8,
    parameter int GROUP_LOG2 = 3,
    localparam int SUM_W     = SAMPLE_W + GROUP_LOG2
) (
    input  blksum_pkg::blk_mode_e mode,
    input  logic [SUM_W-1:0]      total,
    output logic [SUM_W-1:0]      value
);
    // Pick the full sum or the shifted average.
    always_comb begin
        if (mode == blksum_pkg::MODE_AVG)
            value = total >> GROUP_LOG2;
        else
            value = total;
    end
endmodule

// File: rtl/blksum_decim.sv
`timescale 1ns/1ps
// Per-channel block-sum decimator: groups 2**GROUP_LOG2 samples of each
// channel and emits one block value when the group completes, in the same
// cycle as its last sample. Assumes unsigned samples and in_chan < NUM_CH.
module blksum_decim #(
    parameter int NUM_CH     = 16,
    parameter int SAMPLE_W   = 8,
    parameter int GROUP_LOG2 = 3,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int SUM_W     = SAMPLE_W + GROUP_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [CH_W-1:0]      in_chan,
    input  logic [SAMPLE_W-1:0]  in_data,
    input  logic                 avg_mode,
    output logic                 out_valid,
    output logic [CH_W-1:0]      out_chan,
    output logic [SUM_W-1:0]     out_value
);
    logic [SUM_W-1:0] part_a [NUM_CH];
    logic [NUM_CH-1:0] last_a;
    logic [SUM_W-1:0] sel_part;
    logic             sel_last;
    logic [SUM_W-1:0] total;

    // One lane per channel, each enabled only by its own samples.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        blksum_lane #(
            .SAMPLE_W  (SAMPLE_W),
            .GROUP_LOG2(GROUP_LOG2)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .take  (in_valid && (in_chan == CH_W'(g))),
            .sample(in_data),
            .part  (part_a[g]),
            .last  (last_a[g])
        );
    end

    // Fetch the addressed lane's state.
    always_comb begin
        sel_part = '0;
        sel_last = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (in_chan == CH_W'(i)) begin
                sel_part = part_a[i];
                sel_last = last_a[i];
            end
        end
    end

    assign total = sel_part + SUM_W'(in_data);

    blksum_shape #(
        .SAMPLE_W  (SAMPLE_W),
        .GROUP_LOG2(GROUP_LOG2)
    ) u_shape (
        .mode (blksum_pkg::blk_mode_e'(avg_mode)),
        .total(total),
        .value(out_value)
    );

    assign out_valid = rst_n && in_valid && sel_last;
    assign out_chan  = in_chan;
endmodule

// File: rtl/blksum_decim_chk.sv
`timescale 1ns/1ps
// Property checker for blksum_decim; keeps its own sample counts per channel.
module blksum_decim_chk #(
    parameter int NUM_CH     = 16,
    parameter int SAMPLE_W   = 8,
    parameter int GROUP_LOG2 = 3,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int SUM_W     = SAMPLE_W + GROUP_LOG2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [CH_W-1:0]     in_chan,
    input logic                avg_mode,
    input logic                out_valid,
    input logic [CH_W-1:0]     out_chan,
    input logic [SUM_W-1:0]    out_value
);
    logic [GROUP_LOG2-1:0] seen [NUM_CH];

    // Independent tally of samples accepted per channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) seen[i] <= '0;
        end else if (in_valid) begin
            for (int i = 0; i < NUM_CH; i++)
                if (in_chan == CH_W'(i)) seen[i] <= seen[i] + 1'b1;
        end
    end

    AST_QUIET_IN_RESET: assert property (@(posedge clk) !rst_n |-> !out_valid); // R1
    AST_STROBE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (out_valid == (seen[in_chan] == {GROUP_LOG2{1'b1}}))); // R2
    AST_SUM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !avg_mode) |-> (32'(out_value) <= ((1 << GROUP_LOG2) * ((1 << SAMPLE_W) - 1)))); // R3
    AST_AVG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && avg_mode) |-> ((out_value >> SAMPLE_W) == '0)); // R4
    AST_TAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_chan == in_chan)); // R6
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !out_valid); // R7
endmodule

bind blksum_decim blksum_decim_chk #(
    .NUM_CH    (NUM_CH),
    .SAMPLE_W  (SAMPLE_W),
    .GROUP_LOG2(GROUP_LOG2)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_chan  (in_chan),
    .avg_mode (avg_mode),
    .out_valid(out_valid),
    .out_chan (out_chan),
    .out_value(out_value)
);

// File: tb/sim_blksum_decim.sv
`timescale 1ns/1ps
module sim_blksum_decim;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_chan = '0;
    logic [7:0]  in_data = '0;
    logic        avg_mode = 1'b0;
    logic        out_valid;
    logic [3:0]  out_chan;
    logic [10:0] out_value;

    int nchk = 0;
    int nerr = 0;
    int mcnt [16];
    int msum [16];
    string vtag = "R3";

    blksum_decim u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
        .in_data(in_data), .avg_mode(avg_mode), .out_valid(out_valid),
        .out_chan(out_chan), .out_value(out_value)
    );

    always #2.5 clk = ~clk;

    task automatic check(input int act, input int exp, input string tag);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 16; i++) begin
            mcnt[i] = 0;
            msum[i] = 0;
        end
    endtask

    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1; in_chan = 4'd0; in_data = 8'hA5;
        #1;
        check(out_valid, 0, "R1 strobe in reset");
        repeat (cycles) @(negedge clk);
        #1;
        check(out_valid, 0, "R1 strobe in reset");
        clear_model();
        rst_n = 1'b1;
        in_valid = 1'b0;
    endtask

    // Present one sample, compare the combinational outputs, update model.
    task automatic send(input int ch, input int d);
        int exp_s;
        bit exp_v;
        @(negedge clk);
        in_valid = 1'b1; in_chan = 4'(ch); in_data = 8'(d);
        #1;
        exp_v = (mcnt[ch] == 7);
        exp_s = msum[ch] + d;
        check(out_valid, exp_v, "R2 strobe");
        if (exp_v) begin
            check(out_chan, ch, "R6 channel tag");
            check(out_value, avg_mode ? (exp_s >> 3) : exp_s, vtag);
            mcnt[ch] = 0;
            msum[ch] = 0;
        end else begin
            mcnt[ch]++;
            msum[ch] = exp_s;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_chan = 4'(i * 5); in_data = 8'(i * 29 + 3);
            #1;
            check(out_valid, 0, "R7 idle strobe");
        end
    endtask

    initial begin
        #1_000_000;
        nerr++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
        $finish;
    end

    initial begin
        clear_model();
        do_reset(3);

        // R3 R5 R8: round-robin sweep in sum mode, several blocks per channel.
        vtag = "R3 R5 R8 sum";
        for (int rnd = 0; rnd < 3; rnd++)
            for (int k = 0; k < 8; k++)
                for (int ch = 0; ch < 16; ch++)
                    send(ch, (ch * 37 + k * 11 + rnd * 53) & 255);

        // R3: extreme blocks, all-255 then all-zero on one channel.
        vtag = "R3 max sum";
        for (int k = 0; k < 8; k++) send(5, 255);
        vtag = "R3 zero sum";
        for (int k = 0; k < 8; k++) send(5, 0);

        // R5 R7: uneven interleave with idle gaps carrying garbage.
        vtag = "R5 R7 interleave";
        for (int k = 0; k < 40; k++) begin
            send((k * 7) % 3 + 9, (k * 91 + 17) & 255);
            if (k % 5 == 0) idle(2);
        end
        idle(4);

        // R4: average mode sweep, including maximal blocks.
        avg_mode = 1'b1;
        vtag = "R4 average";
        for (int rnd = 0; rnd < 2; rnd++)
            for (int k = 0; k < 8; k++)
                for (int ch = 0; ch < 16; ch++)
                    send(ch, (ch * 13 + k * 71 + rnd * 7 + 100) & 255);
        for (int k = 0; k < 8; k++) send(2, 255);
        for (int k = 0; k < 8; k++) send(2, 15 + k);

        // R9: mode flips inside a group; only the emit-cycle mode matters.
        vtag = "R9 mode at emit";
        for (int k = 0; k < 7; k++) begin
            avg_mode = k[0];
            send(4, 200 + k);
        end
        avg_mode = 1'b0;
        send(4, 250);
        for (int k = 0; k < 7; k++) begin
            avg_mode = ~k[0];
            send(4, 90 + k);
        end
        avg_mode = 1'b1;
        send(4, 33);
        avg_mode = 1'b0;

        // R1 R8: reset in the middle of a group discards the partial data.
        vtag = "R1 post-reset sum";
        for (int k = 0; k < 5; k++) send(3, 240);
        for (int k = 0; k < 3; k++) send(12, 111);
        do_reset(2);
        for (int k = 0; k < 8; k++) send(3, k + 1);
        for (int k = 0; k < 8; k++) send(12, 10 * k);

        idle(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
        $finish;
    end
endmodule